// File: doc/BRIEF.md
# Programmable Threshold Switch with Power-On State

This block is the digital decision stage behind a magnetic gear-tooth sensor. Each sample-valid strobe delivers a signed field sample. The block compares the sample against an operate point and a release point and drives one open-drain-style output bit. The bit goes low while a tooth is present and returns high when the field falls away.

The operate point comes from a 7-bit magnitude code and a range-polarity bit, both taken from a fuse register. The polarity bit moves the operate point into the negative range. It never inverts the sense of the output. The release point always sits a fixed hysteresis below the operate point.

From reset the output is held high. It stays high for a settling window counted in sample strobes; at the nominal 250 kHz sample rate, 12 strobes cover roughly 48 µs. Only after that window does the comparison drive the output.

Top module: `hall_thresh_switch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_n` is 1 (high, released).
- R2: The first `POR_SAMPLES` (default 12) strobes after reset are ignored, and `out_n` stays 1 whatever the sample is. The strobe after them is the first one evaluated.
- R3: On an evaluated strobe where `field` is strictly greater than the operate point, `out_n` is 0 in the cycle after the strobe edge.
- R4: On an evaluated strobe where `field` is strictly less than the release point, `out_n` is 1 in the cycle after the strobe edge.
- R5: On an evaluated strobe where release point <= `field` <= operate point, `out_n` keeps its previous value.
- R6: In a cycle where `field_vld` is 0, `out_n` does not change, whatever `field`, `op_code` or `op_neg` do.
- R7: The operate point is BASE + s*STEP, with s = `op_code` when `op_neg` = 0 and s = -`op_code` when `op_neg` = 1 (defaults BASE = 0, STEP = 16). The result is clamped to the signed `SAMPLE_W`-bit range. `op_neg` does not invert the output: a field above a negative operate point still drives `out_n` low.
- R8: The release point is the operate point minus HYST (default 48), clamped at the most negative sample value (-2048 for 12 bits). For example, code 127 with `op_neg` = 1 gives operate -2032 and release -2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| field_vld | input | 1 | Sample-valid strobe, one cycle per sample |
| field | input | SAMPLE_W (12) | Signed field sample, two's complement |
| op_code | input | CODE_W (7) | Operate-point magnitude code from the fuse register |
| op_neg | input | 1 | Range-polarity bit: 1 selects the negative code range |
| out_n | output | 1 | Switch output: 0 = tooth present (pulled low), 1 = released |

## Verification
The assertions assume that `op_code` and `op_neg` are stable in any cycle where `field_vld` is high. The thresholds they compare against are the ones seen at that strobe edge. The assertions also assume `field` is a valid two's-complement sample on the strobe. The stimulus changes code, polarity and field only at the falling clock edge, and it holds them across the strobe cycle. Between strobes it deliberately changes all three so the hold behaviour is exercised, and every randomly drawn value stays within the declared widths.

// File: rtl/hts_pkg.sv
package hts_pkg;

    typedef struct packed {
        logic out_n;
    } sw_state_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/hts_thr_calc.sv
module hts_thr_calc #(
    parameter int SAMPLE_W = 12,
    parameter int CODE_W   = 7,
    parameter int BASE     = 0,
    parameter int STEP     = 16,
    parameter int HYST     = 48
) (
    input  logic [CODE_W-1:0]          code,
    input  logic                       neg,
    output logic signed [SAMPLE_W-1:0] op_thr,
    output logic signed [SAMPLE_W-1:0] rel_thr
);
    import hts_pkg::*;

    localparam int SMAX = (2 ** (SAMPLE_W - 1)) - 1;
    localparam int SMIN = -(2 ** (SAMPLE_W - 1));

    int signed_code;
    int op_i;
    int rel_i;

    always_comb begin
        signed_code = neg ? -int'(code) : int'(code);
        op_i        = clamp_int(BASE + signed_code * STEP, SMIN, SMAX);
        rel_i       = clamp_int(op_i - HYST, SMIN, SMAX);
    end

    assign op_thr  = op_i[SAMPLE_W-1:0];
    assign rel_thr = rel_i[SAMPLE_W-1:0];

endmodule

// File: rtl/hts_por_timer.sv
module hts_por_timer #(
    parameter int POR_SAMPLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic done
);
    localparam int CW = (POR_SAMPLES < 2) ? 1 : $clog2(POR_SAMPLES + 1);

    generate
        if (POR_SAMPLES == 0) begin : g_none
            assign done = 1'b1;
        end else begin : g_count
            typedef struct packed {
                logic [CW-1:0] cnt;
                logic          done;
            } por_t;

            por_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (tick && !st_q.done) begin
                    if (st_q.cnt == CW'(POR_SAMPLES - 1)) begin
                        st_d.done = 1'b1;
                    end
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign done = st_q.done;
        end
    endgenerate

endmodule

// File: rtl/hall_thresh_switch.sv
module hall_thresh_switch #(
    parameter int SAMPLE_W    = 12,
    parameter int CODE_W      = 7,
    parameter int BASE        = 0,
    parameter int STEP        = 16,
    parameter int HYST        = 48,
    parameter int POR_SAMPLES = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       field_vld,
    input  logic signed [SAMPLE_W-1:0] field,
    input  logic [CODE_W-1:0]          op_code,
    input  logic                       op_neg,
    output logic                       out_n
);
    import hts_pkg::*;

    logic signed [SAMPLE_W-1:0] op_thr;
    logic signed [SAMPLE_W-1:0] rel_thr;
    logic                       por_done;
    sw_state_t                  sw_d, sw_q;

    hts_thr_calc #(
        .SAMPLE_W(SAMPLE_W),
        .CODE_W  (CODE_W),
        .BASE    (BASE),
        .STEP    (STEP),
        .HYST    (HYST)
    ) u_thr (
        .code   (op_code),
        .neg    (op_neg),
        .op_thr (op_thr),
        .rel_thr(rel_thr)
    );

    hts_por_timer #(
        .POR_SAMPLES(POR_SAMPLES)
    ) u_por (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (field_vld),
        .done (por_done)
    );

    always_comb begin
        sw_d = sw_q;
        if (field_vld) begin
            if (!por_done) begin
                sw_d.out_n = 1'b1;
            end else if (field > op_thr) begin
                sw_d.out_n = 1'b0;
            end else if (field < rel_thr) begin
                sw_d.out_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q.out_n <= 1'b1;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign out_n = sw_q.out_n;

endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
    parameter int SAMPLE_W = 12,
    parameter int HYST     = 48
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       field_vld,
    input logic signed [SAMPLE_W-1:0] field,
    input logic signed [SAMPLE_W-1:0] op_thr,
    input logic signed [SAMPLE_W-1:0] rel_thr,
    input logic                       por_done,
    input logic                       out_n
);
    localparam int SMIN = -(2 ** (SAMPLE_W - 1));

    AST_POR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !por_done |-> out_n); // R2

    AST_TOOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (field_vld && por_done && (field > op_thr)) |=> !out_n); // R3

    AST_VALLEY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (field_vld && por_done && (field < rel_thr)) |=> out_n); // R4

    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (field_vld && por_done && (field >= rel_thr) && (field <= op_thr)) |=> $stable(out_n)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !field_vld |=> $stable(out_n)); // R6

    AST_REL_BELOW_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_thr <= op_thr) &&
        ((int'(op_thr) - int'(rel_thr) == HYST) || (int'(rel_thr) == SMIN))); // R8

endmodule

bind hall_thresh_switch hts_checker #(
    .SAMPLE_W(SAMPLE_W),
    .HYST    (HYST)
) u_hts_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .field_vld(field_vld),
    .field    (field),
    .op_thr   (op_thr),
    .rel_thr  (rel_thr),
    .por_done (por_done),
    .out_n    (out_n)
);

// File: tb/hall_thresh_switch_bench.sv
`timescale 1ns/1ps
module hall_thresh_switch_bench;

    localparam int SW   = 12;
    localparam int CW   = 7;
    localparam int BASE = 0;
    localparam int STEP = 16;
    localparam int HYST = 48;
    localparam int POR  = 12;
    localparam int SMAX = 2047;
    localparam int SMIN = -2048;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 field_vld = 1'b0;
    logic signed [SW-1:0] field = '0;
    logic [CW-1:0]        op_code = '0;
    logic                 op_neg = 1'b0;
    logic                 out_n;

    int n_checks = 0;
    int n_fail   = 0;
    int m_strobes = 0;
    logic m_out = 1'b1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hall_thresh_switch #(
        .SAMPLE_W(SW), .CODE_W(CW), .BASE(BASE), .STEP(STEP),
        .HYST(HYST), .POR_SAMPLES(POR)
    ) u_hall_thresh_switch (
        .clk(clk), .rst_n(rst_n), .field_vld(field_vld), .field(field),
        .op_code(op_code), .op_neg(op_neg), .out_n(out_n)
    );

    function automatic int lim(input int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic int exp_op(input int code, input bit neg);
        return lim(BASE + (neg ? -code : code) * STEP);
    endfunction

    function automatic int exp_rel(input int code, input bit neg);
        return lim(exp_op(code, neg) - HYST);
    endfunction

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (out_n !== exp) begin
            n_fail++;
            $display("FAIL %s: out_n actual=%b expected=%b", req, out_n, exp);
        end
    endtask

    task automatic strobe(input int s, input int code, input bit neg, input string force_req);
        string req;
        int op, rel;
        @(negedge clk);
        field = s[SW-1:0];
        op_code = code[CW-1:0];
        op_neg = neg;
        field_vld = 1'b1;
        op = exp_op(code, neg);
        rel = exp_rel(code, neg);
        if (m_strobes < POR) begin
            req = "R2";
            m_out = 1'b1;
        end else if (s > op) begin
            req = "R3";
            m_out = 1'b0;
        end else if (s < rel) begin
            req = "R4";
            m_out = 1'b1;
        end else begin
            req = "R5";
        end
        if (force_req != "") req = force_req;
        m_strobes++;
        @(negedge clk);
        field_vld = 1'b0;
        check(m_out, req);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            field = 12'($urandom_range(0, 4095));
            op_code = 7'($urandom_range(0, 127));
            op_neg = 1'($urandom_range(0, 1));
        end
        @(negedge clk);
        check(m_out, "R6");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(1'b1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b1, "R1");

        // R2: strong tooth field during the settling window is ignored
        for (int i = 0; i < POR; i++) strobe(2000, 0, 1'b0, "R2");

        // R3 / R5 / R4 with code 10 positive: operate 160, release 112
        strobe(161, 10, 1'b0, "R3");
        strobe(160, 10, 1'b0, "R5");
        strobe(112, 10, 1'b0, "R5");
        idle(5);
        strobe(111, 10, 1'b0, "R4");
        strobe(160, 10, 1'b0, "R5");

        // R7: negative range, operate -160, release -208; output sense kept
        strobe(-150, 10, 1'b1, "R7");
        idle(4);
        strobe(-209, 10, 1'b1, "R7");
        strobe(-159, 10, 1'b1, "R7");
        strobe(-208, 10, 1'b1, "R7");

        // R8: code 127 negative, operate -2032, release clamped at -2048
        strobe(-2000, 127, 1'b1, "R8");
        strobe(-2048, 127, 1'b1, "R8");
        strobe(-2032, 127, 1'b1, "R8");
        // top of range: code 127 positive, operate 2032
        strobe(2047, 127, 1'b0, "R7");
        strobe(1983, 127, 1'b0, "R8");
        strobe(1984, 127, 1'b0, "R8");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int c;
            bit ng;
            int op;
            c  = $urandom_range(0, 127);
            ng = 1'($urandom_range(0, 1));
            op = exp_op(c, ng);
            if ($urandom_range(0, 3) == 0)
                strobe(lim(op - HYST + int'($urandom_range(0, 100)) - 50), c, ng, "");
            else
                strobe(int'($urandom_range(0, 4095)) - 2048, c, ng, "");
            if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 4)));
        end

        // R2 again after a second reset
        @(negedge clk);
        rst_n = 1'b0;
        m_out = 1'b1;
        m_strobes = 0;
        @(negedge clk);
        check(1'b1, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < POR; i++) strobe(1500, 5, 1'b0, "R2");
        strobe(1500, 5, 1'b0, "R3");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule